// File: doc/BRIEF.md
# Dual-Unit Floating-Point Issue Scoreboard

This block sits between an instruction decoder and two floating-point execution units: one multiplier and one add/subtract unit, which run independently of each other. Each cycle it may accept one decoded operation. An operation carries an opcode class, an operand size, two source register indices and one destination register index. The block routes each operation to the unit that matches its class. It keeps issuing new work while the required unit is idle, even when the other unit is still computing.

A busy bit is kept for every 32-bit floating-point register. When an operation issues, every register in its destination group is marked busy. A later operation that reads or writes any marked register is held off until the owning unit returns its completion pulse. Registers may be grouped in pairs, which form 64-bit operands, or in fours, which form 128-bit operands. A grouped operand must start on a matching index boundary, and the busy check and the busy marking both cover the whole group. Each unit holds at most one operation at a time. It reports completion with a single-cycle pulse that carries the destination tag, and the scoreboard uses the record it stored at issue to clear the busy bits.

Top module: `fpsb_top`

## Requirements
- R1: Class code 00 (multiply) issues on the multiplier port. Class codes 01 (add) and 10 (subtract) issue on the adder port, with `add_sub` high for subtract only. The destination index and size code are forwarded on the chosen port, and at most one issue pulse is high in a cycle.
- R2: An operation whose unit is idle and whose registers are not busy issues in the cycle it is presented, even while the other unit is busy.
- R3: An operation whose target unit holds an uncompleted operation stalls (`in_ready` low) until that unit's completion pulse. It issues on the first clock edge after the pulse cycle.
- R4: An operation that reads or writes a register marked busy stalls. This covers both a source that matches a pending destination and a destination that matches a pending destination.
- R5: A completion pulse clears the busy marks of that unit's destination group at the end of the pulse cycle. A waiting operation therefore sees `in_ready` high in the following cycle. With a multiply latency of 4 and an add latency of 3, a dependent operation presented right after issue stalls for 4 and 3 cycles respectively.
- R6: Size code 00 is one 32-bit register, 01 is an aligned pair and 10 is an aligned group of four. All operands of an operation share the size. The busy check and the busy marking cover every register of each group.
- R7: A size-01 operand with an odd index, or a size-10 operand whose index is not a multiple of four, raises `illegal` in the cycle it is presented. The operation is accepted (`in_ready` high), does not issue and marks no register busy.
- R8: Class code 11 and size code 11 are reserved. They are treated like R7: `illegal` is raised and nothing issues.
- R9: After reset no register and no unit is busy, so a legal operation is immediately ready and no issue pulse is high while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded operation present |
| in_ready | output | 1 | Operation accepted on this edge if valid |
| in_cls | input | 2 | Class: 00 mul, 01 add, 10 sub, 11 reserved |
| in_size | input | 2 | Size: 00 single, 01 pair, 10 quad, 11 reserved |
| in_src_a | input | 5 | First source register index |
| in_src_b | input | 5 | Second source register index |
| in_dst | input | 5 | Destination register index |
| illegal | output | 1 | Presented operation has a bad operand or code |
| mul_issue | output | 1 | Issue pulse to the multiplier |
| mul_dst | output | 5 | Destination tag for the multiplier |
| mul_size | output | 2 | Size code for the multiplier |
| add_issue | output | 1 | Issue pulse to the adder |
| add_sub | output | 1 | Adder performs subtract |
| add_dst | output | 5 | Destination tag for the adder |
| add_size | output | 2 | Size code for the adder |
| mul_done | input | 1 | Multiplier completion pulse |
| mul_done_tag | input | 5 | Destination tag of the finished multiply |
| add_done | input | 1 | Adder completion pulse |
| add_done_tag | input | 5 | Destination tag of the finished add |

## Verification
The assertions check several properties on every cycle. No issue reaches a unit that is still occupied. A completion pulse arrives only from an occupied unit, exactly one latency after issue and with the stored tag. Newly marked registers were free and are busy afterwards, and an illegal operation never produces an issue pulse. Other behaviour can only be shown by the bench's scenarios, because it depends on timing: the exact stall length for unit contention and for read-after-write and write-after-write dependences, the reach of pair and quad groups into neighbouring registers, and the fact that a rejected operation leaves no busy mark behind.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

    localparam int FP_NREG = 32;
    localparam int FP_IDXW = $clog2(FP_NREG);
    localparam int FP_NUNIT = 2;

    typedef logic [FP_IDXW-1:0] reg_idx_t;
    typedef logic [FP_NREG-1:0] reg_mask_t;

    typedef enum logic [1:0] {
        CLS_MUL = 2'd0,
        CLS_ADD = 2'd1,
        CLS_SUB = 2'd2,
        CLS_RSV = 2'd3
    } op_cls_e;

    typedef enum logic [1:0] {
        SZ_S   = 2'd0,
        SZ_D   = 2'd1,
        SZ_Q   = 2'd2,
        SZ_RSV = 2'd3
    } op_size_e;

    typedef struct packed {
        op_cls_e  cls;
        op_size_e size;
        reg_idx_t src_a;
        reg_idx_t src_b;
        reg_idx_t dst;
    } fp_op_t;

    function automatic int unsigned grp_words(op_size_e s);
        case (s)
            SZ_D:    return 2;
            SZ_Q:    return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic idx_aligned(reg_idx_t i, op_size_e s);
        case (s)
            SZ_S:    return 1'b1;
            SZ_D:    return (i[0] == 1'b0);
            SZ_Q:    return (i[1:0] == 2'b00);
            default: return 1'b0;
        endcase
    endfunction

    function automatic reg_mask_t grp_mask(reg_idx_t i, op_size_e s);
        reg_mask_t m;
        m = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(grp_words(s)) && (int'(i) + k) < FP_NREG)
                m[int'(i) + k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fpsb_decode.sv
module fpsb_decode
    import fpsb_pkg::*;
(
    input  fp_op_t    op,
    output logic      legal,
    output logic      to_mul,
    output logic      is_sub,
    output reg_mask_t chk_mask,
    output reg_mask_t dst_mask
);
    logic codes_ok;
    logic align_ok;

    always_comb begin
        codes_ok = (op.cls != CLS_RSV) && (op.size != SZ_RSV);
        align_ok = idx_aligned(op.src_a, op.size)
                && idx_aligned(op.src_b, op.size)
                && idx_aligned(op.dst, op.size);
        legal    = codes_ok && align_ok;
        to_mul   = (op.cls == CLS_MUL);
        is_sub   = (op.cls == CLS_SUB);
        dst_mask = grp_mask(op.dst, op.size);
        chk_mask = grp_mask(op.src_a, op.size)
                 | grp_mask(op.src_b, op.size)
                 | dst_mask;
    end
endmodule

// File: rtl/fpsb_regbusy.sv
module fpsb_regbusy
    import fpsb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_mask_t chk_mask,
    input  logic      set_en,
    input  reg_mask_t set_mask,
    input  reg_mask_t clr_mask,
    output logic      hazard
);
    reg_mask_t busy_q;

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= '0;
        else
            busy_q <= (busy_q & ~clr_mask) | (set_en ? set_mask : '0);
    end

    assign hazard = |(busy_q & chk_mask);

    // R4: a new destination group is never laid over a pending one
    a_r4_set_on_free: assert property (@(posedge clk) disable iff (rst)
        set_en |-> ((set_mask & busy_q) == '0));

    // R5: completions only release registers that were held
    a_r5_clear_held: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~busy_q) == '0));

    // R6: every register of a newly issued group is marked afterwards
    a_r6_group_marked: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((busy_q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/fpsb_unit_track.sv
module fpsb_unit_track
    import fpsb_pkg::*;
#(
    parameter int LAT = 4
)(
    input  logic      clk,
    input  logic      rst,
    input  logic      issue,
    input  reg_idx_t  issue_dst,
    input  op_size_e  issue_size,
    input  logic      done,
    input  reg_idx_t  done_tag,
    output logic      busy,
    output reg_mask_t clr_mask
);
    localparam int CW = $clog2(LAT + 1);

    logic          busy_q;
    reg_idx_t      dst_q;
    op_size_e      size_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            dst_q  <= '0;
            size_q <= SZ_S;
            cnt_q  <= '0;
        end else if (issue) begin
            busy_q <= 1'b1;
            dst_q  <= issue_dst;
            size_q <= issue_size;
            cnt_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy     = busy_q;
    assign clr_mask = done ? grp_mask(dst_q, size_q) : '0;

    // R3: a unit never receives work while it holds an operation
    a_r3_issue_when_free: assert property (@(posedge clk) disable iff (rst)
        issue |-> !busy_q);

    // R5: completion comes from an occupied unit after exactly LAT cycles
    a_r5_done_on_time: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_q && cnt_q == CW'(LAT - 1)));

    // R5: the returned tag names the stored destination
    a_r5_tag_match: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_tag == dst_q));
endmodule

// File: rtl/fpsb_top.sv
module fpsb_top
    import fpsb_pkg::*;
#(
    parameter int MUL_LAT = 4,
    parameter int ADD_LAT = 3
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_cls,
    input  logic [1:0]         in_size,
    input  logic [FP_IDXW-1:0] in_src_a,
    input  logic [FP_IDXW-1:0] in_src_b,
    input  logic [FP_IDXW-1:0] in_dst,
    output logic               illegal,
    output logic               mul_issue,
    output logic [FP_IDXW-1:0] mul_dst,
    output logic [1:0]         mul_size,
    output logic               add_issue,
    output logic               add_sub,
    output logic [FP_IDXW-1:0] add_dst,
    output logic [1:0]         add_size,
    input  logic               mul_done,
    input  logic [FP_IDXW-1:0] mul_done_tag,
    input  logic               add_done,
    input  logic [FP_IDXW-1:0] add_done_tag
);
    localparam int UNIT_LAT [FP_NUNIT] = '{MUL_LAT, ADD_LAT};

    fp_op_t    op;
    logic      legal, to_mul, is_sub, hazard, unit_busy, fire;
    reg_mask_t chk_mask, dst_mask, clr_mask;

    logic [FP_NUNIT-1:0] u_issue, u_done, u_busy;
    reg_idx_t            u_tag [FP_NUNIT];
    reg_mask_t           u_clr [FP_NUNIT];

    always_comb begin
        op.cls   = op_cls_e'(in_cls);
        op.size  = op_size_e'(in_size);
        op.src_a = in_src_a;
        op.src_b = in_src_b;
        op.dst   = in_dst;
    end

    fpsb_decode u_dec (
        .op       (op),
        .legal    (legal),
        .to_mul   (to_mul),
        .is_sub   (is_sub),
        .chk_mask (chk_mask),
        .dst_mask (dst_mask)
    );

    assign unit_busy = to_mul ? u_busy[0] : u_busy[1];
    assign fire      = in_valid && legal && !unit_busy && !hazard;
    assign in_ready  = !legal || (!unit_busy && !hazard);
    assign illegal   = in_valid && !legal;

    assign u_issue[0] = fire && to_mul;
    assign u_issue[1] = fire && !to_mul;
    assign u_done[0]  = mul_done;
    assign u_done[1]  = add_done;
    assign u_tag[0]   = mul_done_tag;
    assign u_tag[1]   = add_done_tag;

    genvar g;
    generate
        for (g = 0; g < FP_NUNIT; g++) begin : g_unit
            fpsb_unit_track #(.LAT(UNIT_LAT[g])) u_trk (
                .clk        (clk),
                .rst        (rst),
                .issue      (u_issue[g]),
                .issue_dst  (op.dst),
                .issue_size (op.size),
                .done       (u_done[g]),
                .done_tag   (u_tag[g]),
                .busy       (u_busy[g]),
                .clr_mask   (u_clr[g])
            );
        end
    endgenerate

    always_comb begin
        clr_mask = '0;
        for (int u = 0; u < FP_NUNIT; u++)
            clr_mask = clr_mask | u_clr[u];
    end

    fpsb_regbusy u_busy_regs (
        .clk      (clk),
        .rst      (rst),
        .chk_mask (chk_mask),
        .set_en   (fire),
        .set_mask (dst_mask),
        .clr_mask (clr_mask),
        .hazard   (hazard)
    );

    assign mul_issue = u_issue[0];
    assign mul_dst   = in_dst;
    assign mul_size  = in_size;
    assign add_issue = u_issue[1];
    assign add_sub   = is_sub;
    assign add_dst   = in_dst;
    assign add_size  = in_size;

    // R1: an operation goes to at most one unit
    a_r1_one_unit: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mul_issue, add_issue}));

    // R7: a rejected operation never reaches a unit
    a_r7_illegal_no_issue: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(mul_issue || add_issue));
endmodule

// File: tb/tb_fpsb_top.sv
module tb_fpsb_top;
    localparam int MUL_LAT = 4;
    localparam int ADD_LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_cls = 2'd0, in_size = 2'd0;
    logic [4:0] in_src_a = 5'd0, in_src_b = 5'd0, in_dst = 5'd0;
    logic       illegal, mul_issue, add_issue, add_sub;
    logic [4:0] mul_dst, add_dst;
    logic [1:0] mul_size, add_size;
    logic       mul_done, add_done;
    logic [4:0] mul_tag, add_tag;
    logic [3:0] mul_cnt, add_cnt;

    fpsb_top #(.MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_size(in_size), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst), .illegal(illegal),
        .mul_issue(mul_issue), .mul_dst(mul_dst), .mul_size(mul_size),
        .add_issue(add_issue), .add_sub(add_sub), .add_dst(add_dst),
        .add_size(add_size), .mul_done(mul_done), .mul_done_tag(mul_tag),
        .add_done(add_done), .add_done_tag(add_tag)
    );

    // Fixed-latency unit models: pulse done LAT cycles after the issue edge
    always @(posedge clk) begin
        if (rst) begin
            mul_cnt <= '0; add_cnt <= '0; mul_tag <= '0; add_tag <= '0;
        end else begin
            if (mul_issue) begin mul_cnt <= 4'(MUL_LAT); mul_tag <= mul_dst; end
            else if (mul_cnt != 0) mul_cnt <= mul_cnt - 1'b1;
            if (add_issue) begin add_cnt <= 4'(ADD_LAT); add_tag <= add_dst; end
            else if (add_cnt != 0) add_cnt <= add_cnt - 1'b1;
        end
    end
    assign mul_done = (mul_cnt == 4'd1);
    assign add_done = (add_cnt == 4'd1);

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int   stalls;
    logic cap_mul, cap_add, cap_sub, cap_ill;
    logic [4:0] cap_mdst, cap_adst;
    logic [1:0] cap_msize, cap_asize;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] c, input logic [1:0] s,
                        input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_cls = c; in_size = s;
        in_src_a = a; in_src_b = b; in_dst = d;
        #1;
        stalls = 0;
        while (!in_ready && stalls < 50) begin
            @(negedge clk); #1;
            stalls++;
        end
        cap_mul = mul_issue; cap_add = add_issue; cap_sub = add_sub;
        cap_ill = illegal; cap_mdst = mul_dst; cap_adst = add_dst;
        cap_msize = mul_size; cap_asize = add_size;
        @(posedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0; in_cls = 2'd0; in_size = 2'd0;
        in_src_a = 5'd0; in_src_b = 5'd0; in_dst = 5'd0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R9 ready after reset", in_ready, 1);
        chk("R9 no mul issue when idle", mul_issue, 0);
        chk("R9 no add issue when idle", add_issue, 0);
    endtask

    task automatic t_route();
        send(2'd0, 2'd0, 5'd1, 5'd2, 5'd3);
        chk("R1 mul routed", cap_mul, 1);
        chk("R1 mul not on adder", cap_add, 0);
        chk("R1 mul dst", cap_mdst, 3);
        chk("R1 mul size", cap_msize, 0);
        send(2'd2, 2'd1, 5'd4, 5'd6, 5'd8);
        chk("R2 sub issues while mul busy", stalls, 0);
        chk("R1 sub on adder", cap_add, 1);
        chk("R1 sub flag", cap_sub, 1);
        chk("R1 add dst", cap_adst, 8);
        chk("R1 add size", cap_asize, 1);
        drain();
        send(2'd1, 2'd0, 5'd9, 5'd9, 5'd10);
        chk("R1 add flag low", cap_sub, 0);
        chk("R1 add on adder", cap_add, 1);
        drain();
    endtask

    task automatic t_unit_busy();
        send(2'd0, 2'd0, 5'd1, 5'd1, 5'd2);
        send(2'd1, 2'd0, 5'd3, 5'd3, 5'd4);
        chk("R2 add behind mul no stall", stalls, 0);
        send(2'd0, 2'd0, 5'd5, 5'd5, 5'd6);
        chk("R3 third op waits for mul", stalls, 3);
        chk("R3 third op on mul", cap_mul, 1);
        drain();
        send(2'd1, 2'd0, 5'd1, 5'd1, 5'd2);
        send(2'd1, 2'd0, 5'd3, 5'd3, 5'd4);
        chk("R3 second add waits for adder", stalls, 3);
        drain();
    endtask

    task automatic t_reg_busy();
        send(2'd0, 2'd0, 5'd1, 5'd1, 5'd6);
        send(2'd1, 2'd0, 5'd6, 5'd1, 5'd7);
        chk("R4 R5 read after mul write", stalls, 4);
        drain();
        send(2'd1, 2'd0, 5'd1, 5'd1, 5'd8);
        send(2'd0, 2'd0, 5'd2, 5'd2, 5'd8);
        chk("R4 R5 write after add write", stalls, 3);
        drain();
        send(2'd0, 2'd0, 5'd1, 5'd1, 5'd9);
        send(2'd1, 2'd0, 5'd2, 5'd9, 5'd3);
        chk("R4 second source busy", stalls, 4);
        drain();
    endtask

    task automatic t_groups();
        send(2'd0, 2'd1, 5'd0, 5'd0, 5'd10);
        send(2'd1, 2'd0, 5'd11, 5'd1, 5'd2);
        chk("R6 pair upper word busy", stalls, 4);
        drain();
        send(2'd0, 2'd2, 5'd0, 5'd0, 5'd12);
        send(2'd1, 2'd0, 5'd1, 5'd15, 5'd2);
        chk("R6 quad top word busy", stalls, 4);
        drain();
        send(2'd0, 2'd2, 5'd0, 5'd0, 5'd12);
        send(2'd1, 2'd0, 5'd16, 5'd17, 5'd20);
        chk("R6 quad does not reach next reg", stalls, 0);
        drain();
        send(2'd0, 2'd0, 5'd1, 5'd1, 5'd13);
        send(2'd1, 2'd2, 5'd12, 5'd0, 5'd4);
        chk("R6 quad source covers busy word", stalls, 4);
        drain();
    endtask

    task automatic t_illegal();
        send(2'd0, 2'd1, 5'd0, 5'd0, 5'd3);
        chk("R7 odd pair flagged", cap_ill, 1);
        chk("R7 odd pair accepted", stalls, 0);
        chk("R7 odd pair no mul issue", cap_mul, 0);
        send(2'd1, 2'd0, 5'd3, 5'd3, 5'd3);
        chk("R7 no busy mark left", stalls, 0);
        chk("R7 follow-up issued", cap_add, 1);
        drain();
        send(2'd1, 2'd2, 5'd0, 5'd6, 5'd8);
        chk("R7 quad misaligned flagged", cap_ill, 1);
        chk("R7 quad misaligned no issue", cap_add, 0);
        send(2'd1, 2'd1, 5'd5, 5'd2, 5'd4);
        chk("R7 odd pair source flagged", cap_ill, 1);
        send(2'd3, 2'd0, 5'd1, 5'd1, 5'd1);
        chk("R8 reserved class flagged", cap_ill, 1);
        chk("R8 reserved class no issue", int'(cap_mul) + int'(cap_add), 0);
        send(2'd0, 2'd3, 5'd0, 5'd0, 5'd0);
        chk("R8 reserved size flagged", cap_ill, 1);
        chk("R8 reserved size no issue", cap_mul, 0);
        send(2'd0, 2'd0, 5'd0, 5'd0, 5'd0);
        chk("R8 legal op after rejects", cap_ill, 0);
        chk("R8 legal op issues", cap_mul, 1);
        drain();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_route();
        t_unit_busy();
        t_reg_busy();
        t_groups();
        t_illegal();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule